// File: doc/BRIEF.md
# Counter-Ramp ADC Sequencer

This block sequences a staircase analog-to-digital conversion built from an external DAC and one external comparator. The sequencer drives the DAC with a binary code. The comparator reports back whether the DAC output is still under the analog input. When a start request arrives, the code is cleared to zero. The code then climbs by one step per clock for as long as the comparator says the feedback is below the input. The climb halts on the first cycle where the feedback is at or above the input. That code is stored as the result, and a done level is raised.

Because the comparator gates the climb directly, the conversion time grows with the input. An input of value k takes k+1 clock edges after the start is taken. If the code reaches the top value while the comparator still reports "below", the conversion ends with the full-scale code and an over-range flag. Every conversion climbs again from zero, so the block does not track a moving input.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: After synchronous reset, done, busy, over-range, the DAC code and the result are all zero.
- R2: A start request seen at a clock edge while the block is not busy is accepted, and after that edge the DAC code is zero and busy is high.
- R3: While busy and the feedback-below input is high, the DAC code rises by exactly one per clock edge.
- R4: On the first busy edge where feedback-below is low, the current DAC code is stored as the result, over-range is cleared, done goes high and busy goes low.
- R5: For an ideal comparator with integer input k below 2^WIDTH, done is first seen k+1 clock edges after the accepting edge, and the result equals k.
- R6: If feedback-below is still high at the edge where the DAC code equals 2^WIDTH-1, the conversion ends with the result at 2^WIDTH-1 and over-range high, 2^WIDTH edges after the accepting edge.
- R7: After a conversion ends, the result, over-range, DAC code and done stay unchanged until the next start request, whatever the comparator does.
- R8: Done is a level that stays high until a new start request is accepted, and is low after the accepting edge.
- R9: A start request while busy has no effect: the climb, the result and the timing are the same as without it.
- R10: Done and busy are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion start request |
| fb_below_i | input | 1 | Comparator: DAC feedback is below the analog input |
| dac_code_o | output | WIDTH | Code driven to the external DAC |
| busy_o | output | 1 | Conversion in progress |
| eoc_o | output | 1 | Conversion done, result valid (level) |
| result_o | output | WIDTH | Stored conversion result |
| over_range_o | output | 1 | Input was above the top code |

## Verification
Two events can land on the same edge: the comparator trip that ends a conversion, and a start request that arrives while the block is still busy. The bench raises start exactly on the edge where the ideal comparator flips, using a chosen input level. It then checks that done rises with the right result, and that done stays high on the next cycle instead of a new conversion starting. A second case pairs the top-code edge with the trip decision: an input of 2^WIDTH-1 must end without over-range, and an input of 2^WIDTH must end with it.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;

    // Sequencer phases.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    // Per-cycle control word from the sequencer to the datapath.
    typedef struct packed {
        logic clear;    // load zero into the step counter
        logic step;     // advance the step counter by one
        logic capture;  // store the counter value as the result
        logic over;     // value of the over-range flag on capture
    } ramp_ctl_t;

    function automatic logic start_taken(input phase_e ph, input logic req);
        return req && (ph != PH_RUN);
    endfunction

endpackage

// File: rtl/ramp_step_counter.sv
module ramp_step_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             step_i,
    output logic [WIDTH-1:0] count_o,
    output logic             at_top_o
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic [WIDTH-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (clear_i) begin
            count_q <= '0;
        end else if (step_i) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count_o  = count_q;
    assign at_top_o = (count_q == TOP);
endmodule

// File: rtl/ramp_seq_fsm.sv
module ramp_seq_fsm
    import ramp_adc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      below_i,
    input  logic      at_top_i,
    output ramp_ctl_t ctl_o,
    output logic      busy_o,
    output logic      eoc_o
);
    phase_e phase_q, phase_d;

    always_comb begin
        phase_d = phase_q;
        ctl_o   = '0;
        unique case (phase_q)
            PH_RUN: begin
                if (below_i && !at_top_i) begin
                    ctl_o.step = 1'b1;
                end else begin
                    ctl_o.capture = 1'b1;
                    ctl_o.over    = below_i;
                    phase_d       = PH_DONE;
                end
            end
            default: begin
                if (start_taken(phase_q, start_i)) begin
                    ctl_o.clear = 1'b1;
                    phase_d     = PH_RUN;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign busy_o = (phase_q == PH_RUN);
    assign eoc_o  = (phase_q == PH_DONE);
endmodule

// File: rtl/ramp_result_reg.sv
module ramp_result_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture_i,
    input  logic             over_i,
    input  logic [WIDTH-1:0] code_i,
    output logic [WIDTH-1:0] result_o,
    output logic             over_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            result_o <= '0;
            over_o   <= 1'b0;
        end else if (capture_i) begin
            result_o <= code_i;
            over_o   <= over_i;
        end
    end
endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl
    import ramp_adc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             fb_below_i,
    output logic [WIDTH-1:0] dac_code_o,
    output logic             busy_o,
    output logic             eoc_o,
    output logic [WIDTH-1:0] result_o,
    output logic             over_range_o
);
    ramp_ctl_t        ctl;
    logic             at_top;
    logic [WIDTH-1:0] count;

    ramp_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .below_i  (fb_below_i),
        .at_top_i (at_top),
        .ctl_o    (ctl),
        .busy_o   (busy_o),
        .eoc_o    (eoc_o)
    );

    ramp_step_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clear_i  (ctl.clear),
        .step_i   (ctl.step),
        .count_o  (count),
        .at_top_o (at_top)
    );

    ramp_result_reg #(.WIDTH(WIDTH)) u_res (
        .clk       (clk),
        .rst       (rst),
        .capture_i (ctl.capture),
        .over_i    (ctl.over),
        .code_i    (count),
        .result_o  (result_o),
        .over_o    (over_range_o)
    );

    assign dac_code_o = count;
endmodule

// File: rtl/ramp_adc_ctrl_chk.sv
module ramp_adc_ctrl_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             fb_below_i,
    input logic [WIDTH-1:0] dac_code_o,
    input logic             busy_o,
    input logic             eoc_o,
    input logic [WIDTH-1:0] result_o,
    input logic             over_range_o
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (busy_o && !eoc_o && dac_code_o == '0)); // R2

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy_o && fb_below_i && dac_code_o != TOP) |=> (busy_o && dac_code_o == $past(dac_code_o) + 1'b1)); // R3

    AST_TRIP_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !fb_below_i) |=> (eoc_o && !over_range_o && result_o == $past(dac_code_o))); // R4

    AST_TOP_OVER: assert property (@(posedge clk) disable iff (rst)
        (busy_o && fb_below_i && dac_code_o == TOP) |=> (eoc_o && over_range_o && result_o == TOP)); // R6

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (eoc_o && !start_i) |=> (eoc_o && $stable(result_o) && $stable(over_range_o) && $stable(dac_code_o))); // R7

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && fb_below_i && dac_code_o != TOP) |=> (busy_o && !eoc_o)); // R9

    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        eoc_o |-> !busy_o); // R10
endmodule

bind ramp_adc_ctrl ramp_adc_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .fb_below_i   (fb_below_i),
    .dac_code_o   (dac_code_o),
    .busy_o       (busy_o),
    .eoc_o        (eoc_o),
    .result_o     (result_o),
    .over_range_o (over_range_o)
);

// File: tb/test_ramp_adc_ctrl.sv
module test_ramp_adc_ctrl;
    localparam int W     = 8;
    localparam int NVEC  = 8;
    localparam int FULL  = 1 << W;

    // Stimulus input level and expected result/over-range flag.
    localparam logic [W:0]   VEC_AIN  [NVEC] = '{9'd0, 9'd1, 9'd5, 9'd100, 9'd255, 9'd256, 9'd200, 9'd254};
    localparam logic [W-1:0] VEC_CODE [NVEC] = '{8'd0, 8'd1, 8'd5, 8'd100, 8'd255, 8'd255, 8'd200, 8'd254};
    localparam logic         VEC_OVR  [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [W:0]   ain = '0;
    logic         fb_below;
    logic [W-1:0] dac_code;
    logic         busy, eoc, over_range;
    logic [W-1:0] result;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    // Ideal DAC plus comparator.
    assign fb_below = ({1'b0, dac_code} < ain);

    ramp_adc_ctrl #(.WIDTH(W)) i_ramp_adc_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .fb_below_i   (fb_below),
        .dac_code_o   (dac_code),
        .busy_o       (busy),
        .eoc_o        (eoc),
        .result_o     (result),
        .over_range_o (over_range)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Runs one conversion. pulse_at >= 0 raises start for the edge after
    // the sample with that many edges counted since the accepting edge.
    task automatic convert(input logic [W:0] level, input logic [W-1:0] exp_code,
                           input logic exp_ovr, input int pulse_at);
        int n;
        int bad_steps;
        int exp_n;
        ain = level;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R2 code zero after start", int'(dac_code), 0);
        check("R8 done low after start", int'(eoc), 0);
        n = 0;
        bad_steps = 0;
        while (!eoc && n <= FULL + 2) begin
            start_i = (n == pulse_at);
            @(negedge clk);
            start_i = 1'b0;
            n++;
            if (!eoc && int'(dac_code) != n) bad_steps++;
        end
        exp_n = exp_ovr ? FULL : int'(level) + 1;
        check("R3 one step per edge", bad_steps, 0);
        check("R5 edges to done", n, exp_n);
        check("R4 result", int'(result), int'(exp_code));
        check("R6 over-range flag", int'(over_range), int'(exp_ovr));
        check("R10 busy low when done", int'(busy), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not end");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 done", int'(eoc), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 code", int'(dac_code), 0);
        check("R1 result", int'(result), 0);
        check("R1 over", int'(over_range), 0);

        for (int i = 0; i < NVEC; i++) begin
            convert(VEC_AIN[i], VEC_CODE[i], VEC_OVR[i], -1);
        end

        // R7: result held while comparator input moves after done
        ain = 9'd3;
        repeat (6) @(negedge clk);
        check("R7 result held", int'(result), 254);
        check("R7 done held", int'(eoc), 1);
        check("R7 code frozen", int'(dac_code), 254);
        ain = 9'd300;
        repeat (4) @(negedge clk);
        check("R7 over held", int'(over_range), 0);
        check("R7 result held high input", int'(result), 254);

        // R9: start pulsed in the middle of a climb
        convert(9'd40, 8'd40, 1'b0, 17);

        // R9: start on the same edge as the comparator trip
        convert(9'd12, 8'd12, 1'b0, 12);
        @(negedge clk);
        check("R9 done kept after coincident start", int'(eoc), 1);
        check("R9 no restart after coincident start", int'(busy), 0);

        // Over-range after a full-scale run clears on next conversion.
        convert(9'd256, 8'd255, 1'b1, -1);
        convert(9'd7, 8'd7, 1'b0, -1);

        // R1: reset in the middle of a conversion
        ain = 9'd90;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 busy after mid reset", int'(busy), 0);
        check("R1 code after mid reset", int'(dac_code), 0);
        check("R1 result after mid reset", int'(result), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule